// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address and a single fault code. It decides which of four routes the fetch takes: the privileged bypass, a plain physical request, the kernel-only direct-mapped window, or a normal page mapping. For a normal mapping it receives one candidate entry read from the external translation table and checks it against the fetch. That check covers the page tag, the address-space number and the global bit, and then the execute-enable bit for the current privilege level. The result then goes through a final stage. That stage rejects addresses above the implemented physical width and rewrites uncached addresses.

Each request is presented with `req_vld` for one cycle. The registered result appears on the `rsp_*` outputs on the following cycle, marked by `rsp_vld`. Pages are 8 KB and the physical address is 44 bits wide. The table array, the refill handler and all event counting sit outside this block.

The route choice is a decode named by the `route_e` type. `RT_BYPASS` is taken when PC bit 0 is set. `RT_DIRECT` is taken when the physical-request flag is set. `RT_BADVA` is taken for a non-canonical address. `RT_SUPER` is taken for the direct-mapped window, and `RT_MAPPED` covers everything else. Only the single result register holds state. It moves from idle to holding a result whenever `req_vld` is seen, and returns to idle when it is not.

Top module: `ift_xlate`

## Requirements
- R1: While `rst_n` is low, `rsp_vld` is 0, `rsp_fault` is 0 and `rsp_pa` is 0, even if `req_vld` is high.
- R2: A request sampled with `req_vld` high produces `rsp_vld` high on the next clock edge. A cycle without `req_vld` produces `rsp_vld` low on the next edge.
- R3: When `fetch_pc_b0` is 1, `rsp_pa` is `req_va[43:2]` followed by two zero bits. In that case the fault is 0 and `rsp_unc` is 0, whatever the mode, the canonical form, the table entry, or bit 43.
- R4: When `fetch_pc_b0` is 0 and `req_phys` is 1, the physical address is `req_va` unchanged, and it still goes through the checks of R10 and R11.
- R5: Otherwise, an address whose bits 63:47 are not all equal raises fault code 1 (access violation).
- R6: A canonical address with bits 47:41 equal to 0x7E is the direct window. When `cur_mode` is not 0 (kernel), it raises code 1. Otherwise its physical address is `req_va[39:0]`, with bits 43:40 all copied from `req_va[40]`.
- R7: Any other address hits only if `ent_vld` is 1, `ent_tag` equals `req_va[47:13]`, and either `ent_glb` is 1 or `ent_asn` equals `cur_asn`. A miss raises code 2.
- R8: On a hit, the physical address is `ent_ppn` shifted left by 13, plus `req_va[12:0]` with bits 1:0 cleared.
- R9: On a hit, bit `ent_xen[cur_mode]` must be 1, where mode 0 is kernel, 1 executive, 2 supervisor and 3 user. A zero raises code 1.
- R10: After R4, R6 or R8, any set bit at position 44 or above raises code 3 (machine check).
- R11: If bit 43 of that address is set and bits 43:20 are all ones, the request raises code 4 (unimplemented space). Otherwise, when bit 43 is set, `rsp_unc` is 1 and bits 42:35 of `rsp_pa` are cleared.
- R12: Faults rank in this order: bypass, non-canonical, window mode, miss, execute permission, machine check, unimplemented. A response with a nonzero fault has `rsp_pa` 0 and `rsp_unc` 0. Fault codes range from 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request present this cycle |
| req_va | input | 64 | Fetch virtual address |
| fetch_pc_b0 | input | 1 | Bit 0 of the fetch PC (privileged bypass) |
| req_phys | input | 1 | Address is already physical |
| cur_mode | input | 2 | Current privilege level, 0 kernel to 3 user |
| cur_asn | input | 8 | Current address-space number |
| ent_vld | input | 1 | Candidate table entry valid |
| ent_tag | input | 35 | Candidate entry virtual page number |
| ent_asn | input | 8 | Candidate entry address-space number |
| ent_glb | input | 1 | Candidate entry matches any address space |
| ent_ppn | input | 32 | Candidate entry physical page number |
| ent_xen | input | 4 | Candidate entry execute enable, one bit per mode |
| rsp_vld | output | 1 | Result valid |
| rsp_pa | output | 44 | Physical address (0 on a fault) |
| rsp_unc | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | 0 none, 1 access violation, 2 miss, 3 machine check, 4 unimplemented |

## Verification
The bench goes after the bypass with a non-canonical, bit-43 address in user mode. A design that lets the bypass fall into the later checks would report a violation or flag the fetch uncached. It also tests a foreign-ASN entry with and without the global bit, the window with bit 40 set and clear, and the internal-register corner of the uncached space. Sign extension of the window, bits 42:35 being left in place, or the ASN being ignored each give a wrong address or a wrong code. Paired vectors that trip two faults at once (a miss with no permission, a denied page with an out-of-range frame) expose a fault ranking done in the wrong order.

// File: rtl/ift_pkg.sv
package ift_pkg;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ACV   = 3'd1,
        FLT_MISS  = 3'd2,
        FLT_MCHK  = 3'd3,
        FLT_UNIMP = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        RT_BYPASS,
        RT_DIRECT,
        RT_BADVA,
        RT_SUPER,
        RT_MAPPED
    } route_e;

endpackage

// File: rtl/ift_route.sv
module ift_route
    import ift_pkg::*;
#(
    parameter int AW      = 64,
    parameter int VA_IMPL = 48,
    parameter int SP_W    = 7,
    parameter logic [SP_W-1:0] SP_TAG = 7'h7E,
    localparam int SPL    = VA_IMPL - SP_W
) (
    input  logic [AW-1:SPL] va_hi,
    input  logic            pal,
    input  logic            phys,
    output route_e          route
);
    logic canon;
    logic in_window;

    // sign region: every bit from the top down to the highest implemented bit
    assign canon     = (&va_hi[AW-1:VA_IMPL-1]) | ~(|va_hi[AW-1:VA_IMPL-1]);
    assign in_window = (va_hi[VA_IMPL-1:SPL] == SP_TAG);

    always_comb begin
        if (pal)             route = RT_BYPASS;
        else if (phys)       route = RT_DIRECT;
        else if (!canon)     route = RT_BADVA;
        else if (in_window)  route = RT_SUPER;
        else                 route = RT_MAPPED;
    end

endmodule

// File: rtl/ift_tag_match.sv
module ift_tag_match #(
    parameter int AW       = 64,
    parameter int VPN_W    = 35,
    parameter int ASN_W    = 8,
    parameter int PPN_W    = 32,
    parameter int PG_SHIFT = 13,
    parameter int MODE_W   = 2,
    localparam int NMODE   = 1 << MODE_W,
    localparam int FILL    = AW - PPN_W - PG_SHIFT
) (
    input  logic [VPN_W-1:0]    vpn,
    input  logic [PG_SHIFT-1:0] pg_off,
    input  logic [ASN_W-1:0]    cur_asn,
    input  logic [MODE_W-1:0]   mode,
    input  logic                ent_vld,
    input  logic [VPN_W-1:0]    ent_tag,
    input  logic [ASN_W-1:0]    ent_asn,
    input  logic                ent_glb,
    input  logic [PPN_W-1:0]    ent_ppn,
    input  logic [NMODE-1:0]    ent_xen,
    output logic                hit,
    output logic                exec_ok,
    output logic [AW-1:0]       map_pa
);
    logic            asn_ok;
    logic [AW-1:0]   frame;
    logic [AW-1:0]   offs;

    assign asn_ok  = ent_glb | (ent_asn == cur_asn);
    assign hit     = ent_vld & (ent_tag == vpn) & asn_ok;
    assign exec_ok = ent_xen[mode];

    assign frame  = {{FILL{1'b0}}, ent_ppn, {PG_SHIFT{1'b0}}};
    assign offs   = {{(AW-PG_SHIFT){1'b0}}, pg_off[PG_SHIFT-1:2], 2'b00};
    assign map_pa = frame + offs;

endmodule

// File: rtl/ift_cache_rewrite.sv
module ift_cache_rewrite #(
    parameter int AW     = 64,
    parameter int PA_W   = 44,
    parameter int IPR_LO = 20,
    parameter int CLR_HI = 42,
    parameter int CLR_LO = 35,
    localparam int CLR_N = CLR_HI - CLR_LO + 1,
    localparam logic [PA_W-1:0] CLR_MASK =
        ({PA_W{1'b1}} >> (PA_W - CLR_N)) << CLR_LO
) (
    input  logic [AW-1:0]   pa_in,
    output logic            mchk,
    output logic            ipr,
    output logic            unc,
    output logic [PA_W-1:0] pa_out
);
    assign mchk   = |pa_in[AW-1:PA_W];
    assign unc    = pa_in[PA_W-1];
    assign ipr    = unc & (&pa_in[PA_W-1:IPR_LO]);
    assign pa_out = unc ? (pa_in[PA_W-1:0] & ~CLR_MASK) : pa_in[PA_W-1:0];

endmodule

// File: rtl/ift_xlate.sv
module ift_xlate
    import ift_pkg::*;
#(
    parameter int AW         = 64,
    parameter int VA_IMPL    = 48,
    parameter int PA_W       = 44,
    parameter int PG_SHIFT   = 13,
    parameter int ASN_W      = 8,
    parameter int PPN_W      = 32,
    parameter int MODE_W     = 2,
    parameter int SP_EXT_BIT = 40,
    localparam int VPN_W     = VA_IMPL - PG_SHIFT,
    localparam int NMODE     = 1 << MODE_W,
    localparam int SPL       = VA_IMPL - 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [AW-1:0]     req_va,
    input  logic              fetch_pc_b0,
    input  logic              req_phys,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [ASN_W-1:0]  cur_asn,
    input  logic              ent_vld,
    input  logic [VPN_W-1:0]  ent_tag,
    input  logic [ASN_W-1:0]  ent_asn,
    input  logic              ent_glb,
    input  logic [PPN_W-1:0]  ent_ppn,
    input  logic [NMODE-1:0]  ent_xen,
    output logic              rsp_vld,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_unc,
    output logic [2:0]        rsp_fault
);
    route_e          route;
    logic            hit;
    logic            exec_ok;
    logic [AW-1:0]   map_pa;
    logic [AW-1:0]   sp_pa;
    logic [AW-1:0]   pa_raw;
    logic            post_en;
    fault_e          pre_fault;
    logic            mchk;
    logic            ipr;
    logic            unc_hit;
    logic [PA_W-1:0] rw_pa;
    logic [PA_W-1:0] nxt_pa;
    logic            nxt_unc;
    fault_e          nxt_fault;

    ift_route #(
        .AW(AW), .VA_IMPL(VA_IMPL), .SP_W(7), .SP_TAG(7'h7E)
    ) u_route (
        .va_hi (req_va[AW-1:SPL]),
        .pal   (fetch_pc_b0),
        .phys  (req_phys),
        .route (route)
    );

    ift_tag_match #(
        .AW(AW), .VPN_W(VPN_W), .ASN_W(ASN_W), .PPN_W(PPN_W),
        .PG_SHIFT(PG_SHIFT), .MODE_W(MODE_W)
    ) u_match (
        .vpn     (req_va[VA_IMPL-1:PG_SHIFT]),
        .pg_off  (req_va[PG_SHIFT-1:0]),
        .cur_asn (cur_asn),
        .mode    (cur_mode),
        .ent_vld (ent_vld),
        .ent_tag (ent_tag),
        .ent_asn (ent_asn),
        .ent_glb (ent_glb),
        .ent_ppn (ent_ppn),
        .ent_xen (ent_xen),
        .hit     (hit),
        .exec_ok (exec_ok),
        .map_pa  (map_pa)
    );

    // direct window: low part kept, bits from SP_EXT_BIT up copy that bit
    assign sp_pa = {{(AW-PA_W){1'b0}},
                    {(PA_W-SP_EXT_BIT){req_va[SP_EXT_BIT]}},
                    req_va[SP_EXT_BIT-1:0]};

    always_comb begin
        pa_raw    = '0;
        post_en   = 1'b0;
        pre_fault = FLT_NONE;
        unique case (route)
            RT_BYPASS: ;
            RT_DIRECT: begin
                pa_raw  = req_va;
                post_en = 1'b1;
            end
            RT_BADVA:  pre_fault = FLT_ACV;
            RT_SUPER: begin
                if (cur_mode != MODE_KERN) begin
                    pre_fault = FLT_ACV;
                end else begin
                    pa_raw  = sp_pa;
                    post_en = 1'b1;
                end
            end
            RT_MAPPED: begin
                if (!hit) begin
                    pre_fault = FLT_MISS;
                end else if (!exec_ok) begin
                    pre_fault = FLT_ACV;
                end else begin
                    pa_raw  = map_pa;
                    post_en = 1'b1;
                end
            end
            default: ;
        endcase
    end

    ift_cache_rewrite #(
        .AW(AW), .PA_W(PA_W), .IPR_LO(20), .CLR_HI(PA_W-2), .CLR_LO(35)
    ) u_cache (
        .pa_in  (pa_raw),
        .mchk   (mchk),
        .ipr    (ipr),
        .unc    (unc_hit),
        .pa_out (rw_pa)
    );

    always_comb begin
        nxt_pa    = '0;
        nxt_unc   = 1'b0;
        nxt_fault = pre_fault;
        if (route == RT_BYPASS) begin
            nxt_pa = {req_va[PA_W-1:2], 2'b00};
        end else if (post_en) begin
            if (mchk) begin
                nxt_fault = FLT_MCHK;
            end else if (ipr) begin
                nxt_fault = FLT_UNIMP;
            end else begin
                nxt_pa  = rw_pa;
                nxt_unc = unc_hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_pa    <= '0;
            rsp_unc   <= 1'b0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_vld <= req_vld;
            if (req_vld) begin
                rsp_pa    <= nxt_pa;
                rsp_unc   <= nxt_unc;
                rsp_fault <= nxt_fault;
            end
        end
    end

endmodule

// File: rtl/ift_xlate_chk.sv
module ift_xlate_chk #(
    parameter int AW      = 64,
    parameter int VA_IMPL = 48,
    parameter int PA_W    = 44,
    parameter int MODE_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic [AW-1:0]     req_va,
    input logic              fetch_pc_b0,
    input logic              req_phys,
    input logic [MODE_W-1:0] cur_mode,
    input logic              rsp_vld,
    input logic [PA_W-1:0]   rsp_pa,
    input logic              rsp_unc,
    input logic [2:0]        rsp_fault
);
    logic sp_req;
    assign sp_req = req_vld && !fetch_pc_b0 && !req_phys &&
                    (&req_va[AW-1:VA_IMPL-6]) && !req_va[VA_IMPL-7];

    AST_RSP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld); // R2
    AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && fetch_pc_b0) |=> (rsp_fault == 3'd0 && !rsp_unc && rsp_pa[1:0] == 2'b00)); // R3
    AST_WINDOW_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_req && cur_mode != '0) |=> (rsp_fault == 3'd1)); // R6
    AST_UNC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_unc) |-> (rsp_pa[PA_W-1] && rsp_pa[PA_W-2:35] == '0)); // R11
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_unc)); // R12
    AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_fault <= 3'd4)); // R12

endmodule

bind ift_xlate ift_xlate_chk #(
    .AW(AW), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .MODE_W(MODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_va(req_va),
    .fetch_pc_b0(fetch_pc_b0), .req_phys(req_phys), .cur_mode(cur_mode),
    .rsp_vld(rsp_vld), .rsp_pa(rsp_pa), .rsp_unc(rsp_unc), .rsp_fault(rsp_fault)
);

// File: tb/ift_xlate_test.sv
module ift_xlate_test;

    typedef struct packed {
        logic [63:0] va;
        logic        pal;
        logic        phys;
        logic [1:0]  mode;
        logic [7:0]  asn;
        logic        ev;
        logic [34:0] tag;
        logic [7:0]  easn;
        logic        glb;
        logic [31:0] ppn;
        logic [3:0]  xen;
        logic [43:0] exp_pa;
        logic        exp_unc;
        logic [2:0]  exp_f;
    } vec_t;

    localparam int NV = 22;
    localparam logic [34:0] TG = 35'h91A2;
    localparam logic [63:0] MV = 64'h0000_0000_1234_567B;

    localparam vec_t VECS [NV] = '{
        // R8 R7 mapped hit, kernel, low bits cleared
        '{MV, 0, 0, 2'd0, 8'd5, 1, TG, 8'd5, 0, 32'hABC, 4'b0001, 44'h000_0157_9678, 0, 3'd0},
        // R7 foreign ASN, not global -> miss
        '{MV, 0, 0, 2'd0, 8'd5, 1, TG, 8'd6, 0, 32'hABC, 4'b0001, 44'h0, 0, 3'd2},
        // R7 foreign ASN, global -> hit
        '{MV, 0, 0, 2'd0, 8'd5, 1, TG, 8'd6, 1, 32'hABC, 4'b0001, 44'h000_0157_9678, 0, 3'd0},
        // R7 tag mismatch -> miss
        '{MV, 0, 0, 2'd0, 8'd5, 1, 35'h91A3, 8'd5, 0, 32'hABC, 4'b0001, 44'h0, 0, 3'd2},
        // R12 invalid entry and no permission -> miss wins
        '{MV, 0, 0, 2'd0, 8'd5, 0, TG, 8'd5, 0, 32'hABC, 4'b0000, 44'h0, 0, 3'd2},
        // R9 user denied
        '{MV, 0, 0, 2'd3, 8'd5, 1, TG, 8'd5, 0, 32'hABC, 4'b0111, 44'h0, 0, 3'd1},
        // R9 user allowed
        '{MV, 0, 0, 2'd3, 8'd5, 1, TG, 8'd5, 0, 32'hABC, 4'b1000, 44'h000_0157_9678, 0, 3'd0},
        // R9 executive allowed
        '{MV, 0, 0, 2'd1, 8'd5, 1, TG, 8'd5, 0, 32'hABC, 4'b0010, 44'h000_0157_9678, 0, 3'd0},
        // R12 permission outranks machine check
        '{MV, 0, 0, 2'd0, 8'd5, 1, TG, 8'd5, 0, 32'h8000_0000, 4'b0000, 44'h0, 0, 3'd1},
        // R10 mapped frame beyond 44 bits
        '{MV, 0, 0, 2'd0, 8'd5, 1, TG, 8'd5, 0, 32'h8000_0000, 4'b0001, 44'h0, 0, 3'd3},
        // R11 mapped uncached frame
        '{MV, 0, 0, 2'd0, 8'd5, 1, TG, 8'd5, 0, 32'h4000_0000, 4'b0001, 44'h800_0000_1678, 1, 3'd0},
        // R3 bypass: non-canonical, user, bit 43 set, no entry
        '{64'h8000_0FFF_FFFF_FFFF, 1, 0, 2'd3, 8'd5, 0, TG, 8'd5, 0, 32'h0, 4'b0000, 44'hFFF_FFFF_FFFC, 0, 3'd0},
        // R4 physical request, address unchanged
        '{64'h0000_0000_0012_3457, 0, 1, 2'd3, 8'd5, 0, TG, 8'd5, 0, 32'h0, 4'b0000, 44'h000_0012_3457, 0, 3'd0},
        // R10 physical address bit 44
        '{64'h0000_1000_0000_0000, 0, 1, 2'd0, 8'd5, 0, TG, 8'd5, 0, 32'h0, 4'b0000, 44'h0, 0, 3'd3},
        // R11 physical uncached, bits 42:35 cleared
        '{64'h0000_0FFF_1234_5678, 0, 1, 2'd0, 8'd5, 0, TG, 8'd5, 0, 32'h0, 4'b0000, 44'h807_1234_5678, 1, 3'd0},
        // R11 physical internal-register space
        '{64'h0000_0FFF_FFF0_0010, 0, 1, 2'd0, 8'd5, 0, TG, 8'd5, 0, 32'h0, 4'b0000, 44'h0, 0, 3'd4},
        // R6 window, kernel, bit 40 clear
        '{64'hFFFF_FC00_1234_5678, 0, 0, 2'd0, 8'd5, 0, TG, 8'd5, 0, 32'h0, 4'b0000, 44'h000_1234_5678, 0, 3'd0},
        // R6 window, bit 40 set -> sign extended, uncached
        '{64'hFFFF_FD00_1234_5678, 0, 0, 2'd0, 8'd5, 0, TG, 8'd5, 0, 32'h0, 4'b0000, 44'h800_1234_5678, 1, 3'd0},
        // R6 window from user mode
        '{64'hFFFF_FC00_1234_5678, 0, 0, 2'd3, 8'd5, 0, TG, 8'd5, 0, 32'h0, 4'b0000, 44'h0, 0, 3'd1},
        // R6 window reaching internal-register space
        '{64'hFFFF_FDFF_FFF0_0000, 0, 0, 2'd0, 8'd5, 0, TG, 8'd5, 0, 32'h0, 4'b0000, 44'h0, 0, 3'd4},
        // R5 non-canonical high bit, matching entry present
        '{64'h0001_0000_0000_0000, 0, 0, 2'd0, 8'd5, 1, 35'h0, 8'd5, 0, 32'h1, 4'b1111, 44'h0, 0, 3'd1},
        // R5 non-canonical with bit 47 clear
        '{64'hFFFF_7FFF_0000_0000, 0, 0, 2'd0, 8'd5, 0, TG, 8'd5, 0, 32'h0, 4'b0000, 44'h0, 0, 3'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [63:0] req_va = '0;
    logic        fetch_pc_b0 = 1'b0;
    logic        req_phys = 1'b0;
    logic [1:0]  cur_mode = '0;
    logic [7:0]  cur_asn = '0;
    logic        ent_vld = 1'b0;
    logic [34:0] ent_tag = '0;
    logic [7:0]  ent_asn = '0;
    logic        ent_glb = 1'b0;
    logic [31:0] ent_ppn = '0;
    logic [3:0]  ent_xen = '0;
    logic        rsp_vld;
    logic [43:0] rsp_pa;
    logic        rsp_unc;
    logic [2:0]  rsp_fault;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ift_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_va(req_va),
        .fetch_pc_b0(fetch_pc_b0), .req_phys(req_phys), .cur_mode(cur_mode),
        .cur_asn(cur_asn), .ent_vld(ent_vld), .ent_tag(ent_tag),
        .ent_asn(ent_asn), .ent_glb(ent_glb), .ent_ppn(ent_ppn),
        .ent_xen(ent_xen), .rsp_vld(rsp_vld), .rsp_pa(rsp_pa),
        .rsp_unc(rsp_unc), .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input logic [48:0] act, input logic [48:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {vld,unc,fault,pa} actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        // R1 reset holds outputs quiet even with a request present
        req_vld = 1'b1;
        req_va  = 64'h0000_0000_0012_3457;
        req_phys = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", {rsp_vld, rsp_unc, rsp_fault, rsp_pa}, 49'h0);
        req_vld = 1'b0;
        req_phys = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle after reset", {48'h0, rsp_vld}, 49'h0);

        // table walk, one request per cycle, back to back
        for (int i = 0; i < NV; i++) begin
            req_vld     = 1'b1;
            req_va      = VECS[i].va;
            fetch_pc_b0 = VECS[i].pal;
            req_phys    = VECS[i].phys;
            cur_mode    = VECS[i].mode;
            cur_asn     = VECS[i].asn;
            ent_vld     = VECS[i].ev;
            ent_tag     = VECS[i].tag;
            ent_asn     = VECS[i].easn;
            ent_glb     = VECS[i].glb;
            ent_ppn     = VECS[i].ppn;
            ent_xen     = VECS[i].xen;
            @(negedge clk);
            check($sformatf("R12 vector %0d", i),
                  {rsp_vld, rsp_unc, rsp_fault, rsp_pa},
                  {1'b1, VECS[i].exp_unc, VECS[i].exp_f, VECS[i].exp_pa});
        end

        // R2 no request -> no response
        req_vld = 1'b0;
        @(negedge clk);
        check("R2 drop valid", {48'h0, rsp_vld}, 49'h0);

        // R3 bypass ignores a physical flag carrying an out-of-range address
        req_vld     = 1'b1;
        fetch_pc_b0 = 1'b1;
        req_phys    = 1'b1;
        req_va      = 64'hFFFF_0000_0000_0007;
        @(negedge clk);
        check("R3 bypass over phys", {rsp_vld, rsp_unc, rsp_fault, rsp_pa},
              {1'b1, 1'b0, 3'd0, 44'h000_0000_0004});
        req_vld = 1'b0;
        fetch_pc_b0 = 1'b0;
        req_phys = 1'b0;
        @(negedge clk);

        // R1 reset in the middle of traffic clears the result
        req_vld = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", {rsp_vld, rsp_unc, rsp_fault, rsp_pa}, 49'h0);
        req_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule